// File: doc/BRIEF.md
# Programmable Logic Cell with Carry and Output Register

This block is one programmable cell of a logic fabric. Two 3-input lookup tables either merge into one 4-input function or act as the two operand bits of a full adder. A carry input comes from the previous cell and a carry output goes to the next cell. A D flip-flop can capture the result, and a programmed bit chooses whether the cell drives that flop or the combinational result.

All programmable state sits in a 19-bit serial chain. The chain shifts on each clock while the configuration enable is high. The far end of the chain is brought out on a pin, so several cells can be chained in series and their settings read back by shifting again. While the chain is being loaded, the cell output is held at 0 and the flop is held at its programmed start value.

Top module: `lcell_top`

## Requirements
- R1: While `cfg_en` is 1, each clock shifts `cfg_in` into the chain, first bit first. After 19 shifts the chain holds, from the first bit shifted to the last: table A bit 7 down to bit 0, table B bit 7 down to bit 0, the mode bit, the output-select bit and the flop start bit. `cfg_out` always shows the bit that entered 19 shifts earlier, so a second load reads the first word back in its original order.
- R2: With the mode bit 0 and the output-select bit 0, `cell_out` equals table A (when `din[3]` is 0) or table B (when `din[3]` is 1), indexed by {`din[2]`,`din[1]`,`din[0]`}, with `din[0]` as the least significant bit.
- R3: With the mode bit 1, the two table outputs and `carry_in` enter a full adder. The sum is the cell result and `carry_out` is the majority of the three.
- R4: With the mode bit 0, `carry_out` is 0.
- R5: With the output-select bit 1, `cell_out` shows the flop. On a clock edge with `cfg_en` 0, `srst_n` 1 and `ce` 1, the flop takes the cell result.
- R6: On a clock edge with `cfg_en` 0, `srst_n` 1 and `ce` 0, the flop keeps its value.
- R7: On a clock edge with `cfg_en` 0 and `srst_n` 0, the flop loads the programmed start bit, whatever `ce` is.
- R8: While `cfg_en` is 1, `cell_out` is 0 and each clock loads the flop with the start bit then in the chain. After the last shift, the flop holds the new start bit until the first clock after `cfg_en` falls.
- R9: While `rst_n` is low, the chain and the flop are 0, so `cell_out`, `carry_out` and `cfg_out` are 0. The release of `rst_n` takes effect after two clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_en | input | 1 | Configuration shift enable |
| cfg_in | input | 1 | Serial configuration data in |
| cfg_out | output | 1 | Serial configuration data out, end of the chain |
| din | input | 4 | Cell inputs; bit 3 picks the table in logic mode |
| carry_in | input | 1 | Carry from the previous cell |
| ce | input | 1 | Flop clock enable |
| srst_n | input | 1 | Synchronous active-low load of the start bit |
| carry_out | output | 1 | Carry to the next cell |
| cell_out | output | 1 | Cell output |

## Verification
The combinational result and `carry_out` are due in the same cycle as the inputs change. The bench drives inputs on the falling edge and samples one nanosecond later, before any rising edge. The registered output is due one rising edge after the inputs that it captures, so the bench updates its flop model at that edge and samples one nanosecond after it. The inputs are still unchanged at that point. A bit shifted into the chain reaches `cfg_out` after 19 shifts, so readback is compared before each shift of the next load against the word loaded earlier.

// File: rtl/lcell_pkg.sv
package lcell_pkg;
  localparam int unsigned TBL_IN   = 3;
  localparam int unsigned TBL_BITS = 1 << TBL_IN;
  localparam int unsigned CFG_BITS = 2 * TBL_BITS + 3;

  // Field order from MSB to LSB matches the serial shift order.
  typedef struct packed {
    logic [TBL_BITS-1:0] tbl_a;
    logic [TBL_BITS-1:0] tbl_b;
    logic                arith;
    logic                reg_sel;
    logic                ff_start;
  } cell_cfg_t;
endpackage

// File: rtl/lcell_cfg_chain.sv
module lcell_cfg_chain #(
  parameter int unsigned WIDTH = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             sin,
  output logic [WIDTH-1:0] word_q,
  output logic [WIDTH-1:0] word_d,
  output logic             sout
);
  always_comb begin
    word_d = word_q;
    if (shift_en) word_d = {word_q[WIDTH-2:0], sin};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign sout = word_q[WIDTH-1];
endmodule

// File: rtl/lcell_tbl.sv
module lcell_tbl #(
  parameter int unsigned N_IN = 3,
  localparam int unsigned N_BITS = 1 << N_IN
) (
  input  logic [N_BITS-1:0] contents,
  input  logic [N_IN-1:0]   sel,
  output logic              f
);
  assign f = contents[sel];
endmodule

// File: rtl/lcell_ff.sv
module lcell_ff (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_cfg,
  input  logic start_cfg,
  input  logic start_run,
  input  logic srst_n,
  input  logic ce,
  input  logic d,
  output logic q
);
  logic q_nxt;

  always_comb begin
    q_nxt = q;
    if (hold_cfg)     q_nxt = start_cfg;
    else if (!srst_n) q_nxt = start_run;
    else if (ce)      q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/lcell_top.sv
module lcell_top
  import lcell_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned DIN_W = TBL_IN + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_in,
  output logic             cfg_out,
  input  logic [DIN_W-1:0] din,
  input  logic             carry_in,
  input  logic             ce,
  input  logic             srst_n,
  output logic             carry_out,
  output logic             cell_out
);
  // Reset: asserted at once, released through a synchronizer.
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ns = rst_pipe[SYNC_STAGES-1];

  // Configuration chain.
  logic [CFG_BITS-1:0] cfg_word_q, cfg_word_d;
  cell_cfg_t           cfg_q, cfg_d;

  lcell_cfg_chain #(.WIDTH(CFG_BITS)) u_chain (
    .clk      (clk),
    .rst_n    (rst_ns),
    .shift_en (cfg_en),
    .sin      (cfg_in),
    .word_q   (cfg_word_q),
    .word_d   (cfg_word_d),
    .sout     (cfg_out)
  );
  assign cfg_q = cell_cfg_t'(cfg_word_q);
  assign cfg_d = cell_cfg_t'(cfg_word_d);

  // Two 3-input tables; index 0 is table A, index 1 is table B.
  logic [1:0][TBL_BITS-1:0] tbl_contents;
  logic [1:0]               tbl_f;
  assign tbl_contents = {cfg_q.tbl_b, cfg_q.tbl_a};

  for (genvar t = 0; t < 2; t++) begin : g_tbl
    lcell_tbl #(.N_IN(TBL_IN)) u_tbl (
      .contents (tbl_contents[t]),
      .sel      (din[TBL_IN-1:0]),
      .f        (tbl_f[t])
    );
  end

  // Mode selection: merged table or full adder.
  logic logic_res, sum_res, maj_res, cell_res, ff_q;

  always_comb begin
    logic_res = din[TBL_IN] ? tbl_f[1] : tbl_f[0];
    sum_res   = tbl_f[0] ^ tbl_f[1] ^ carry_in;
    maj_res   = (tbl_f[0] & tbl_f[1]) | (carry_in & (tbl_f[0] ^ tbl_f[1]));
    cell_res  = cfg_q.arith ? sum_res : logic_res;
  end

  assign carry_out = cfg_q.arith & maj_res;

  lcell_ff u_ff (
    .clk       (clk),
    .rst_n     (rst_ns),
    .hold_cfg  (cfg_en),
    .start_cfg (cfg_d.ff_start),
    .start_run (cfg_q.ff_start),
    .srst_n    (srst_n),
    .ce        (ce),
    .d         (cell_res),
    .q         (ff_q)
  );

  assign cell_out = cfg_en ? 1'b0 : (cfg_q.reg_sel ? ff_q : cell_res);
endmodule

// File: rtl/lcell_chk.sv
module lcell_chk (
  input logic        clk,
  input logic        rst_ns,
  input logic        cfg_en,
  input logic        cfg_out,
  input logic [18:0] chain_q,
  input logic        ce,
  input logic        srst_n,
  input logic        ff_q,
  input logic        arith,
  input logic        tbl_a_f,
  input logic        tbl_b_f,
  input logic        carry_out,
  input logic        cell_out
);
  // R1: a shift moves the bit below the end of the chain onto cfg_out.
  a_r1_chain_shift: assert property (@(posedge clk) disable iff (!rst_ns)
    cfg_en |=> cfg_out == $past(chain_q[17]));

  // R1: without a shift the chain end does not move.
  a_r1_chain_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    !cfg_en |=> $stable(cfg_out));

  // R3: both operands high always carry.
  a_r3_carry_gen: assert property (@(posedge clk) disable iff (!rst_ns)
    (arith && tbl_a_f && tbl_b_f) |-> carry_out);

  // R4: logic mode never carries.
  a_r4_no_carry: assert property (@(posedge clk) disable iff (!rst_ns)
    !arith |-> !carry_out);

  // R6: a disabled flop keeps its value.
  a_r6_ce_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    (!cfg_en && srst_n && !ce) |=> $stable(ff_q));

  // R7: the synchronous reset loads the start bit.
  a_r7_srst_load: assert property (@(posedge clk) disable iff (!rst_ns)
    (!cfg_en && !srst_n) |=> ff_q == $past(chain_q[0]));

  // R8: during a shift the flop follows the start bit of the chain.
  a_r8_cfg_flop: assert property (@(posedge clk) disable iff (!rst_ns)
    cfg_en |=> ff_q == chain_q[0]);

  // R8: the output stays low while configuring.
  a_r8_cfg_quiet: assert property (@(posedge clk) disable iff (!rst_ns)
    cfg_en |-> !cell_out);
endmodule

bind lcell_top lcell_chk u_chk (
  .clk       (clk),
  .rst_ns    (rst_ns),
  .cfg_en    (cfg_en),
  .cfg_out   (cfg_out),
  .chain_q   (cfg_word_q),
  .ce        (ce),
  .srst_n    (srst_n),
  .ff_q      (ff_q),
  .arith     (cfg_q.arith),
  .tbl_a_f   (tbl_f[0]),
  .tbl_b_f   (tbl_f[1]),
  .carry_out (carry_out),
  .cell_out  (cell_out)
);

// File: tb/lcell_top_test.sv
module lcell_top_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfg_en, cfg_in, cfg_out;
  logic [3:0] din;
  logic       carry_in, ce, srst_n, carry_out, cell_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [18:0] cur_w;
  logic        ff_m;

  always #2 clk = ~clk;

  lcell_top uut (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_in(cfg_in), .cfg_out(cfg_out),
    .din(din), .carry_in(carry_in), .ce(ce), .srst_n(srst_n),
    .carry_out(carry_out), .cell_out(cell_out)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b (cfg=%h din=%h cin=%b)",
               req, act, exp, cur_w, din, carry_in);
    end
  endtask

  // Word fields: [18:11] table A, [10:3] table B, [2] mode, [1] out select, [0] start.
  function automatic logic res_exp(input logic [18:0] w, input logic [3:0] d, input logic ci);
    logic a, b;
    a = w[11 + d[2:0]];
    b = w[3 + d[2:0]];
    if (w[2]) return a ^ b ^ ci;
    return d[3] ? b : a;
  endfunction

  function automatic logic cout_exp(input logic [18:0] w, input logic [3:0] d, input logic ci);
    logic a, b;
    a = w[11 + d[2:0]];
    b = w[3 + d[2:0]];
    if (!w[2]) return 1'b0;
    return (a & b) | (ci & (a ^ b));
  endfunction

  task automatic load(input logic [18:0] w, input bit readback);
    for (int i = 18; i >= 0; i--) begin
      @(negedge clk);
      cfg_en = 1'b1;
      cfg_in = w[i];
      #1;
      if (readback) check(cfg_out, cur_w[i], "R1 readback");
      check(cell_out, 1'b0, "R8 quiet");
    end
    @(negedge clk);
    cfg_en = 1'b0;
    ce     = 1'b0;
    srst_n = 1'b1;
    cur_w  = w;
    ff_m   = w[0];
    #1;
    if (w[1]) check(cell_out, w[0], "R8 start value");
  endtask

  task automatic step(input logic [3:0] d, input logic ci, input logic e, input logic sr);
    logic r;
    @(negedge clk);
    din = d; carry_in = ci; ce = e; srst_n = sr;
    #1;
    r = res_exp(cur_w, d, ci);
    check(carry_out, cout_exp(cur_w, d, ci), cur_w[2] ? "R3 carry" : "R4 carry");
    if (!cur_w[1]) check(cell_out, r, cur_w[2] ? "R3 sum" : "R2 logic");
    if (!sr)     ff_m = cur_w[0];
    else if (e)  ff_m = r;
    @(posedge clk);
    #1;
    if (cur_w[1]) check(cell_out, ff_m, !sr ? "R7 srst" : (e ? "R5 capture" : "R6 hold"));
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd7041));
    rst_n = 1'b0; cfg_en = 1'b0; cfg_in = 1'b0; din = '0;
    carry_in = 1'b0; ce = 1'b0; srst_n = 1'b1;
    cur_w = '0; ff_m = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check(cell_out, 1'b0, "R9 out");
    check(cfg_out, 1'b0, "R9 cfg_out");
    check(carry_out, 1'b0, "R9 carry");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Directed: logic mode, combinational, table A = 8'hA5, table B = 8'h3C.
    load({8'hA5, 8'h3C, 1'b0, 1'b0, 1'b0}, 1'b1);
    for (int k = 0; k < 16; k++) step(k[3:0], 1'b1, 1'b1, 1'b1);

    // Directed: adder with both tables all ones; carry generate with carry_in 1.
    load({8'hFF, 8'hFF, 1'b1, 1'b0, 1'b1}, 1'b1);
    step(4'h3, 1'b1, 1'b1, 1'b1);
    step(4'h3, 1'b0, 1'b1, 1'b1);

    // Directed: registered, start 1, ce low holds, srst with ce high loads start.
    load({8'h00, 8'hFF, 1'b0, 1'b1, 1'b1}, 1'b1);
    step(4'h0, 1'b0, 1'b0, 1'b1);
    step(4'h0, 1'b0, 1'b1, 1'b1);
    step(4'h8, 1'b0, 1'b0, 1'b1);
    step(4'h0, 1'b0, 1'b1, 1'b0);

    // Random configurations and vectors.
    for (int c = 0; c < 40; c++) begin
      load(19'($urandom), 1'b1);
      for (int v = 0; v < 30; v++)
        step(4'($urandom), 1'($urandom), ($urandom % 4) != 0, ($urandom % 8) != 0);
    end

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule